// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block is the part of an I2C bus master that places a Repeated Start condition on the bus between two transfers. Software asks for it by setting the repeat-start bit of a 5-bit command field. The request is accepted only when the byte engine reports that the bus is idle after a completed byte, with SCL low after the ninth clock. The block then takes over the two open-drain lines and walks them through four timed steps. Each step lasts one period of a reloadable baud counter. While SCL is released, the counter waits for the line to read high, so a slave can stretch the clock.

The sequence steps are: SDA released with SCL still held low, then SCL released, then SDA pulled low with SCL high, then SCL pulled low. At the end, hardware clears the repeat-start bit and sets a start-seen status and an interrupt flag. Both lines stay low until software writes the transmit buffer for the first data bit. That write starts the next transfer.

While the sequence runs, commands are not queued. Command writes are ignored, and a transmit-buffer write is dropped and raises a write-collision flag. Software clears the collision and interrupt flags by writing zero to them.

FSM states: `RS_IDLE` (lines released), `RS_SDA_UP`, `RS_SCL_UP`, `RS_SDA_DN`, `RS_SCL_DN` (the four timed steps), and `RS_HOLD` (both lines low, waiting for the buffer write). The transitions are:
- `RS_IDLE` to `RS_SDA_UP` on an accepted request.
- Each step to the next when the baud counter reports the end of its period.
- `RS_SCL_DN` to `RS_HOLD` on completion.
- `RS_HOLD` to `RS_IDLE` on an accepted buffer write.

Top module: `rsq_top`

## Requirements
- R1: A synchronous active-high reset releases both lines and clears the command field, transmit buffer, start-seen, interrupt flag, write-collision flag and start pulse.
- R2: A command write with bit 1 (repeat-start) set, while the block is idle and `byte_idle` is high, sets bit 1. For the next `brg_reload`+1 cycles, SDA is released while SCL is held low.
- R3: SCL is then released. After the sensed SCL first reads high, the step lasts `brg_reload`+1 more cycles, so any stretch adds its own length.
- R4: SDA is then pulled low with SCL released for `brg_reload`+1 cycles. SDA never starts to be pulled low while SCL is driven low.
- R5: SCL is then pulled low with SDA low for `brg_reload`+1 cycles.
- R6: On completion, in the same cycle, bit 1 clears, and start-seen and the interrupt flag set. Both lines stay driven low until a buffer write is accepted.
- R7: A buffer write while bit 1 is set sets the write-collision flag, leaves the buffer unchanged and gives no start pulse.
- R8: A command write while bit 1 is set leaves all five command bits unchanged.
- R9: A buffer write while bit 1 is clear has three effects one cycle later: the buffer holds the new byte, a one-cycle start pulse is given, and start-seen is clear. If the block was holding the lines, it releases them.
- R10: A repeat-start request while `byte_idle` is low is ignored: bit 1 stays clear and the lines stay released.
- R11: A flag write clears the interrupt flag when its bit 0 is 0, and clears the write-collision flag when its bit 1 is 0. Writing 1 to either bit has no effect.
- R12: A command write with bit 1 clear, made while the block is idle, stores the other four bits and starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_reload | input | CNT_W | Baud counter reload value; one step lasts reload+1 cycles |
| byte_idle | input | 1 | Byte engine idle after a completed byte |
| ctl_wr | input | 1 | Command field write strobe |
| ctl_wdata | input | CMD_W | Command write data; bit 1 is repeat-start |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| flg_wr | input | 1 | Flag write strobe |
| flg_wdata | input | 2 | Bit 0 interrupt, bit 1 collision; 0 clears |
| scl_in | input | 1 | Sensed SCL level |
| scl_low | output | 1 | Drive SCL low (0 = released) |
| sda_low | output | 1 | Drive SDA low (0 = released) |
| cmd_q | output | CMD_W | Command field |
| tx_buf | output | DATA_W | Transmit buffer |
| tx_start | output | 1 | One-cycle pulse: buffer accepted, next transfer starts |
| start_seen | output | 1 | Start status |
| irq_flag | output | 1 | Interrupt flag |
| wcol | output | 1 | Write-collision flag |

## Verification
The bench builds the block with a 4-bit baud counter. It sweeps every reload value from 0 to 5 against clock stretches of 0, 1 and 2 cycles, so the length of each of the four steps is measured for 18 timing combinations. The short counter keeps the whole sweep brief. It also brings within reach the zero-reload case, where every step lasts one cycle and the completion follows closely on a collided write. A stretch value of one also injects buffer and command writes in mid-sequence, followed by bit-by-bit flag clearing.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SDA_UP,
        RS_SCL_UP,
        RS_SDA_DN,
        RS_SCL_DN,
        RS_HOLD
    } rs_state_e;

    localparam int FLG_IRQ  = 0;
    localparam int FLG_WCOL = 1;

endpackage

// File: rtl/rsq_brg.sv
module rsq_brg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The step ends in the cycle where the counter sits at zero and may advance.
    assign tick = run && (cnt == '0);

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic buf_accept,
    input  logic tick,
    input  logic scl_in,
    output logic brg_load,
    output logic brg_run,
    output logic busy,
    output logic idle,
    output logic done,
    output logic sda_low,
    output logic scl_low
);

    rs_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:   if (start_req)  state_nx = RS_SDA_UP;
            RS_SDA_UP: if (tick)       state_nx = RS_SCL_UP;
            RS_SCL_UP: if (tick)       state_nx = RS_SDA_DN;
            RS_SDA_DN: if (tick)       state_nx = RS_SCL_DN;
            RS_SCL_DN: if (tick)       state_nx = RS_HOLD;
            RS_HOLD:   if (buf_accept) state_nx = RS_IDLE;
            default:                   state_nx = RS_IDLE;
        endcase
    end

    always_comb begin
        sda_low = 1'b0;
        scl_low = 1'b0;
        busy    = 1'b0;
        brg_run = 1'b0;
        unique case (state)
            RS_IDLE: ;
            RS_SDA_UP: begin
                scl_low = 1'b1;
                busy    = 1'b1;
                brg_run = 1'b1;
            end
            RS_SCL_UP: begin
                busy    = 1'b1;
                brg_run = scl_in;
            end
            RS_SDA_DN: begin
                sda_low = 1'b1;
                busy    = 1'b1;
                brg_run = 1'b1;
            end
            RS_SCL_DN: begin
                sda_low = 1'b1;
                scl_low = 1'b1;
                busy    = 1'b1;
                brg_run = 1'b1;
            end
            RS_HOLD: begin
                sda_low = 1'b1;
                scl_low = 1'b1;
            end
            default: ;
        endcase
    end

    assign idle     = (state == RS_IDLE);
    assign done     = (state == RS_SCL_DN) && tick;
    assign brg_load = (idle && start_req) || (busy && tick && !done);

endmodule

// File: rtl/rsq_regs.sv
module rsq_regs
    import rsq_pkg::*;
#(
    parameter int CMD_W  = 5,
    parameter int DATA_W = 8,
    parameter int RS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              done,
    input  logic              start_req,
    input  logic              ctl_wr,
    input  logic [CMD_W-1:0]  ctl_wdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              flg_wr,
    input  logic [1:0]        flg_wdata,
    output logic              buf_accept,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_start,
    output logic              start_seen,
    output logic              irq_flag,
    output logic              wcol
);

    assign buf_accept = buf_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            if (ctl_wr && !busy) begin
                cmd_q         <= ctl_wdata;
                cmd_q[RS_BIT] <= start_req;
            end
            if (done) begin
                cmd_q[RS_BIT] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf   <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= buf_accept;
            if (buf_accept) begin
                tx_buf <= buf_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcol       <= 1'b0;
            irq_flag   <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            if (buf_wr && busy) begin
                wcol <= 1'b1;
            end else if (flg_wr && !flg_wdata[FLG_WCOL]) begin
                wcol <= 1'b0;
            end
            if (done) begin
                irq_flag <= 1'b1;
            end else if (flg_wr && !flg_wdata[FLG_IRQ]) begin
                irq_flag <= 1'b0;
            end
            if (done) begin
                start_seen <= 1'b1;
            end else if (buf_accept) begin
                start_seen <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rsq_top.sv
module rsq_top #(
    parameter int CNT_W  = 8,
    parameter int CMD_W  = 5,
    parameter int DATA_W = 8,
    parameter int RS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  brg_reload,
    input  logic              byte_idle,
    input  logic              ctl_wr,
    input  logic [CMD_W-1:0]  ctl_wdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              flg_wr,
    input  logic [1:0]        flg_wdata,
    input  logic              scl_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_start,
    output logic              start_seen,
    output logic              irq_flag,
    output logic              wcol
);

    logic brg_load, brg_run, tick;
    logic busy, idle, done;
    logic start_req, buf_accept;

    assign start_req = ctl_wr && ctl_wdata[RS_BIT] && idle && byte_idle;

    rsq_brg #(.CNT_W(CNT_W)) i_brg (
        .clk    (clk),
        .rst    (rst),
        .load   (brg_load),
        .run    (brg_run),
        .reload (brg_reload),
        .tick   (tick)
    );

    rsq_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .buf_accept (buf_accept),
        .tick       (tick),
        .scl_in     (scl_in),
        .brg_load   (brg_load),
        .brg_run    (brg_run),
        .busy       (busy),
        .idle       (idle),
        .done       (done),
        .sda_low    (sda_low),
        .scl_low    (scl_low)
    );

    rsq_regs #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W),
        .RS_BIT (RS_BIT)
    ) i_regs (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .done       (done),
        .start_req  (start_req),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .flg_wr     (flg_wr),
        .flg_wdata  (flg_wdata),
        .buf_accept (buf_accept),
        .cmd_q      (cmd_q),
        .tx_buf     (tx_buf),
        .tx_start   (tx_start),
        .start_seen (start_seen),
        .irq_flag   (irq_flag),
        .wcol       (wcol)
    );

endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
    parameter int CMD_W  = 5,
    parameter int DATA_W = 8,
    parameter int RS_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_idle,
    input logic              ctl_wr,
    input logic [CMD_W-1:0]  ctl_wdata,
    input logic              buf_wr,
    input logic              scl_low,
    input logic              sda_low,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [DATA_W-1:0] tx_buf,
    input logic              tx_start,
    input logic              start_seen,
    input logic              irq_flag,
    input logic              wcol
);

    logic rs_en;
    assign rs_en = cmd_q[RS_BIT];

    // R2: an accepted request shows SDA released with SCL held low next cycle
    a_r2_begin: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[RS_BIT] && byte_idle && !rs_en && !sda_low && !scl_low)
        |=> (rs_en && !sda_low && scl_low));

    // R4: SDA only starts to be pulled low while SCL is released
    a_r4_sda_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !scl_low);

    // R6: completion sets status and interrupt, lines held low
    a_r6_complete: assert property (@(posedge clk) disable iff (rst)
        $fell(rs_en) |-> (start_seen && irq_flag && sda_low && scl_low));

    // R7: buffer write during the sequence collides and is dropped
    a_r7_collide: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && rs_en) |=> (wcol && !tx_start && (tx_buf == $past(tx_buf))));

    // R8: command writes during the sequence leave the field unchanged
    a_r8_locked: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && rs_en) |=> (cmd_q == $past(cmd_q)));

    // R9: a start pulse comes with start-seen cleared
    a_r9_accept: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !start_seen);

    // R10: request without an idle byte engine is ignored
    a_r10_refuse: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !byte_idle && !rs_en) |=> !rs_en);

endmodule

bind rsq_top rsq_chk #(
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W),
    .RS_BIT (RS_BIT)
) i_rsq_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_idle  (byte_idle),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .buf_wr     (buf_wr),
    .scl_low    (scl_low),
    .sda_low    (sda_low),
    .cmd_q      (cmd_q),
    .tx_buf     (tx_buf),
    .tx_start   (tx_start),
    .start_seen (start_seen),
    .irq_flag   (irq_flag),
    .wcol       (wcol)
);

// File: tb/test_rsq_top.sv
module test_rsq_top;

    localparam int CNT_W  = 4;
    localparam int CMD_W  = 5;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  brg_reload = '0;
    logic              byte_idle = 1'b1;
    logic              ctl_wr = 1'b0;
    logic [CMD_W-1:0]  ctl_wdata = '0;
    logic              buf_wr = 1'b0;
    logic [DATA_W-1:0] buf_wdata = '0;
    logic              flg_wr = 1'b0;
    logic [1:0]        flg_wdata = '0;
    logic              scl_hold = 1'b0;
    logic              scl_in;
    logic              scl_low, sda_low, tx_start, start_seen, irq_flag, wcol;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] tx_buf;

    int nchk = 0;
    int nfail = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    // open-drain bus with pull-up; a slave may stretch SCL
    assign scl_in = !scl_low && !scl_hold;

    rsq_top #(.CNT_W(CNT_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .RS_BIT(1)) i_rsq_top (
        .clk(clk), .rst(rst), .brg_reload(brg_reload), .byte_idle(byte_idle),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .flg_wr(flg_wr), .flg_wdata(flg_wdata), .scl_in(scl_in),
        .scl_low(scl_low), .sda_low(sda_low), .cmd_q(cmd_q), .tx_buf(tx_buf),
        .tx_start(tx_start), .start_seen(start_seen), .irq_flag(irq_flag), .wcol(wcol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    task automatic run_seq(input int r, input int s, input bit inject);
        int c[4];
        int nscl;
        bit seen, injected, pend;
        logic [DATA_W-1:0] old_buf;
        logic [CMD_W-1:0]  old_cmd;
        logic [1:0] ph;
        logic [DATA_W-1:0] val;
        for (int i = 0; i < 4; i++) c[i] = 0;
        nscl = 0; seen = 0; injected = 0; pend = 0;
        old_buf = tx_buf; old_cmd = cmd_q;
        brg_reload = CNT_W'(r);
        scl_hold = (s > 0);
        ctl_wr = 1'b1; ctl_wdata = 5'b00010;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            ctl_wr = 1'b0; buf_wr = 1'b0;
            if (pend) begin
                chk(wcol == 1'b1, "R7 collision flag", int'(wcol), 1);
                chk(tx_buf == old_buf, "R7 buffer kept", int'(tx_buf), int'(old_buf));
                chk(tx_start == 1'b0, "R7 no start pulse", int'(tx_start), 0);
                chk(cmd_q == old_cmd, "R8 command locked", int'(cmd_q), int'(old_cmd));
                pend = 0;
            end
            if (!cmd_q[1]) begin
                if (seen) break;
                chk(1'b0, "R2 request not accepted", 0, 1);
                break;
            end
            seen = 1;
            ph = {sda_low, scl_low};
            c[ph]++;
            if (ph == 2'b00) begin
                nscl++;
                if (nscl >= s + 1) scl_hold = 1'b0;
            end
            if (inject && ph == 2'b10 && !injected) begin
                injected = 1; pend = 1;
                old_buf = tx_buf; old_cmd = cmd_q;
                buf_wr = 1'b1; buf_wdata = ~tx_buf ^ 8'(r);
                ctl_wr = 1'b1; ctl_wdata = 5'b11101;
            end
        end
        scl_hold = 1'b0;
        chk(c[1] == r + 1, "R2 SDA-up step length", c[1], r + 1);
        chk(c[0] == r + 1 + s, "R3 SCL-up step length", c[0], r + 1 + s);
        chk(c[2] == r + 1, "R4 SDA-down step length", c[2], r + 1);
        chk(c[3] == r + 1, "R5 SCL-down step length", c[3], r + 1);
        chk(start_seen && irq_flag, "R6 status and interrupt", int'({start_seen, irq_flag}), 3);
        chk(sda_low && scl_low, "R6 lines held low", int'({sda_low, scl_low}), 3);
        @(negedge clk); @(negedge clk);
        chk(sda_low && scl_low && !tx_start, "R6 still holding", int'({sda_low, scl_low, tx_start}), 6);
        if (inject) begin
            chk(wcol == 1'b1, "R7 collision sticky", int'(wcol), 1);
            flg_wr = 1'b1; flg_wdata = 2'b01;
            @(negedge clk); flg_wr = 1'b0;
            chk(!wcol && irq_flag, "R11 clear collision only", int'({wcol, irq_flag}), 1);
            flg_wr = 1'b1; flg_wdata = 2'b10;
            @(negedge clk); flg_wr = 1'b0;
            chk(!wcol && !irq_flag, "R11 clear interrupt only", int'({wcol, irq_flag}), 0);
        end else begin
            flg_wr = 1'b1; flg_wdata = 2'b00;
            @(negedge clk); flg_wr = 1'b0;
            chk(!wcol && !irq_flag, "R11 clear both flags", int'({wcol, irq_flag}), 0);
        end
        val = 8'(r * 16 + s + 1);
        buf_wr = 1'b1; buf_wdata = val;
        @(negedge clk); buf_wr = 1'b0;
        chk(tx_buf == val, "R9 buffer loaded", int'(tx_buf), int'(val));
        chk(tx_start == 1'b1, "R9 start pulse", int'(tx_start), 1);
        chk(!start_seen, "R9 start-seen cleared", int'(start_seen), 0);
        chk(!sda_low && !scl_low, "R9 lines released", int'({sda_low, scl_low}), 0);
        @(negedge clk);
        chk(tx_start == 1'b0, "R9 pulse one cycle", int'(tx_start), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!scl_low && !sda_low, "R1 lines released", int'({sda_low, scl_low}), 0);
        chk(cmd_q == '0 && tx_buf == '0, "R1 registers clear", int'(cmd_q) + int'(tx_buf), 0);
        chk(!start_seen && !irq_flag && !wcol && !tx_start, "R1 flags clear",
            int'({start_seen, irq_flag, wcol, tx_start}), 0);

        // R12: other command bits stored, no sequence
        ctl_wr = 1'b1; ctl_wdata = 5'b10101;
        @(negedge clk); ctl_wr = 1'b0;
        chk(cmd_q == 5'b10101, "R12 command stored", int'(cmd_q), 21);
        @(negedge clk);
        chk(!scl_low && !sda_low, "R12 no sequence", int'({sda_low, scl_low}), 0);
        ctl_wr = 1'b1; ctl_wdata = 5'b00000;
        @(negedge clk); ctl_wr = 1'b0;

        // R10: request refused while byte engine not idle
        byte_idle = 1'b0;
        ctl_wr = 1'b1; ctl_wdata = 5'b00010;
        @(negedge clk); ctl_wr = 1'b0;
        chk(cmd_q[1] == 1'b0, "R10 enable stays clear", int'(cmd_q[1]), 0);
        repeat (3) @(negedge clk);
        chk(!scl_low && !sda_low, "R10 lines released", int'({sda_low, scl_low}), 0);
        byte_idle = 1'b1;

        for (int r = 0; r <= 5; r++) begin
            for (int s = 0; s <= 2; s++) begin
                run_seq(r, s, s == 1);
            end
        end
        finish_run();
    end

endmodule